// File: doc/BRIEF.md
# Product Code Packet Encoder

This block protects a packet of flits with a two-dimensional product code. Flits arrive one at a time on a valid/ready stream. Each flit is treated as one column of an array. Every flit leaves at once with its own column check bits attached. A systematic Hamming single-error-correcting code over the flit supplies these bits. As the flits stream through, the block keeps a running XOR of them, which is the even-parity row check of every bit row of the array. It never stores the packet's data.

When the last flit of a packet is accepted, the row parity and the column code of that row parity (the checks-on-checks) are latched into a one-flit check buffer. That check flit goes onto the link only when the receiver asks for a retransmission. It is dropped when the next packet starts, and a request that finds the buffer empty does nothing. The first flit of a packet is taken as the start of a new packet. A packet closes on the `in_last` marker or after `MAX_FLITS` flits, whichever comes first.

Top module: `pc_packet_encoder`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and no check flit is buffered, so a retransmit request before the first packet produces no output.
- R2: Every emitted flit is systematic. `out_flit[FLIT_W-1:0]` carries the data and `out_flit[CW-1:FLIT_W]` carries CHK_W Hamming bits. Data bit d takes the d-th codeword position, counting from 1, that is not a power of two (3, 5, 6, 7, 9, ...). Check bit i takes position 2^i. The XOR of the positions of all set bits is zero.
- R3: A flit accepted on a clock edge (`in_valid` and `in_ready` high) is on the output with `out_valid` high right after that edge, and flits leave in arrival order.
- R4: `out_last` is 1 on the final data flit of a packet. A packet closes on a flit with `in_last` high or on its MAX_FLITS-th flit, whichever comes first.
- R5: The data field of the check flit equals the XOR of all data flits of the most recently closed packet.
- R6: The check field of the check flit is the column code of that row parity, so the check flit also satisfies the R2 rule.
- R7: The check flit is emitted only after a retransmit request. It carries `out_chk`=1 and `out_last`=1. Data flits carry `out_chk`=0. After a request seen on edge E, the check flit is valid after edge E+1 when the output is free.
- R8: A request is ignored when no check flit is buffered. This covers a request before any packet, a request after the buffer has been served, and a second request while one is still pending. At most one check flit is sent per packet.
- R9: Accepting the first flit of a new packet discards the buffered check flit. A request in that same cycle, or later within that packet, produces no output.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output flit and its flags hold steady and `in_ready` is 0.
- R11: While a retransmit request is pending, `in_ready` is 0 until the check flit has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Encoder can take a flit |
| in_flit | input | FLIT_W | Uncoded flit |
| in_last | input | 1 | Final flit of the packet |
| out_valid | output | 1 | Coded flit valid |
| out_ready | input | 1 | Link can take a coded flit |
| out_flit | output | CW | Coded flit, check bits above data |
| out_last | output | 1 | Final flit of a data packet, or the check flit |
| out_chk | output | 1 | Flit is the deferred check packet |
| rtx_req | input | 1 | Retransmission request from the receiver |

## Verification
The directed tests go after the edges of the packet lifecycle. One case is a request in the very cycle the next packet's first flit is accepted. A design that served that stale buffer would emit a check flit for the wrong packet. Another is two back-to-back requests. A design that did not clear the buffer on service would send the check flit twice. A packet without `in_last` must close at MAX_FLITS, or the row parity would run into the next packet and the final `out_last` would be missing. Single-flit and short packets check that the accumulator starts fresh instead of folding in the previous packet. Output backpressure and a pending request both test that `in_ready` drops, so that no flit is overwritten or lost.

// File: rtl/pce_pkg.sv
package pce_pkg;

  // Number of Hamming check bits needed to cover w data bits.
  function automatic int hamm_chk_bits(input int w);
    int p;
    p = 1;
    while ((1 << p) < (w + p + 1)) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/pce_col_enc.sv
module pce_col_enc
  import pce_pkg::*;
#(
  parameter int DW = 8,
  localparam int PW = hamm_chk_bits(DW)
) (
  input  logic [DW-1:0] data,
  output logic [PW-1:0] chk
);

  // Data bits of the codeword each check bit covers.
  function automatic logic [DW-1:0] cover_mask(input int ci);
    logic [DW-1:0] m;
    int pos;
    m   = '0;
    pos = 1;
    for (int d = 0; d < DW; d++) begin
      pos++;
      while (is_pow2(pos)) pos++;
      if (((pos >> ci) & 1) == 1) m[d] = 1'b1;
    end
    return m;
  endfunction

  for (genvar i = 0; i < PW; i++) begin : g_chk
    localparam logic [DW-1:0] MASK = cover_mask(i);
    assign chk[i] = ^(data & MASK);
  end

endmodule

// File: rtl/pce_row_acc.sv
module pce_row_acc #(
  parameter int DW        = 8,
  parameter int MAX_FLITS = 4,
  localparam int CNT_W    = (MAX_FLITS > 1) ? $clog2(MAX_FLITS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] flit,
  input  logic          last_mark,
  output logic          first,
  output logic          pkt_end,
  output logic [DW-1:0] row_par
);

  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_FLITS - 1);

  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    acc;

  assign first   = (cnt == '0);
  assign pkt_end = last_mark || (cnt == CNT_TOP);
  // Parity including the flit being taken this cycle.
  assign row_par = first ? flit : (acc ^ flit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      acc <= '0;
    end else if (take) begin
      acc <= row_par;
      cnt <= pkt_end ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pc_packet_encoder.sv
module pc_packet_encoder
  import pce_pkg::*;
#(
  parameter int FLIT_W    = 8,
  parameter int MAX_FLITS = 4,
  localparam int CHK_W    = hamm_chk_bits(FLIT_W),
  localparam int CW       = FLIT_W + CHK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_flit,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CW-1:0]     out_flit,
  output logic              out_last,
  output logic              out_chk,
  input  logic              rtx_req
);

  logic              out_free;
  logic              accept;
  logic              first;
  logic              pkt_end;
  logic [FLIT_W-1:0] row_par;
  logic [CHK_W-1:0]  data_chk;
  logic [CHK_W-1:0]  coc_chk;
  logic              pend;
  logic              buf_valid;
  logic [FLIT_W-1:0] buf_pcb;
  logic [CHK_W-1:0]  buf_coc;

  assign out_free = !out_valid || out_ready;
  assign in_ready = out_free && !pend;
  assign accept   = in_valid && in_ready;

  // Stage 1: column code on each incoming flit.
  pce_col_enc #(.DW(FLIT_W)) u_col_data (
    .data (in_flit),
    .chk  (data_chk)
  );

  // Stage 2: running row parity across the packet.
  pce_row_acc #(.DW(FLIT_W), .MAX_FLITS(MAX_FLITS)) u_row (
    .clk       (clk),
    .rst       (rst),
    .take      (accept),
    .flit      (in_flit),
    .last_mark (in_last),
    .first     (first),
    .pkt_end   (pkt_end),
    .row_par   (row_par)
  );

  // Stage 3: column code on the row parity (checks-on-checks).
  pce_col_enc #(.DW(FLIT_W)) u_col_coc (
    .data (row_par),
    .chk  (coc_chk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_flit  <= '0;
      out_last  <= 1'b0;
      out_chk   <= 1'b0;
      pend      <= 1'b0;
      buf_valid <= 1'b0;
      buf_pcb   <= '0;
      buf_coc   <= '0;
    end else begin
      if (accept && first) buf_valid <= 1'b0;
      if (accept && pkt_end) begin
        buf_valid <= 1'b1;
        buf_pcb   <= row_par;
        buf_coc   <= coc_chk;
      end
      if (rtx_req && buf_valid && !pend && !accept) pend <= 1'b1;

      if (out_free) begin
        if (accept) begin
          out_valid <= 1'b1;
          out_flit  <= {data_chk, in_flit};
          out_last  <= pkt_end;
          out_chk   <= 1'b0;
        end else if (pend) begin
          out_valid <= 1'b1;
          out_flit  <= {buf_coc, buf_pcb};
          out_last  <= 1'b1;
          out_chk   <= 1'b1;
          pend      <= 1'b0;
          buf_valid <= 1'b0;
        end else begin
          out_valid <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/pce_checker.sv
module pce_checker
  import pce_pkg::*;
#(
  parameter int FLIT_W    = 8,
  localparam int CHK_W    = hamm_chk_bits(FLIT_W),
  localparam int CW       = FLIT_W + CHK_W
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [CW-1:0] out_flit,
  input logic          out_last,
  input logic          out_chk
);

  function automatic int syndrome(input logic [CW-1:0] cw);
    int s;
    int pos;
    s   = 0;
    pos = 1;
    for (int d = 0; d < FLIT_W; d++) begin
      pos++;
      while (is_pow2(pos)) pos++;
      if (cw[d]) s = s ^ pos;
    end
    for (int i = 0; i < CHK_W; i++)
      if (cw[FLIT_W+i]) s = s ^ (1 << i);
    return s;
  endfunction

  // R2 R6
  codeword_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (syndrome(out_flit) == 0));

  // R3
  accept_emits_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R7
  check_flit_last_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_chk) |-> out_last);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_flit) && $stable(out_last) && $stable(out_chk)));

  // R10
  stall_input_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

bind pc_packet_encoder pce_checker #(.FLIT_W(FLIT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_flit  (out_flit),
  .out_last  (out_last),
  .out_chk   (out_chk)
);

// File: tb/pc_packet_encoder_tb.sv
module pc_packet_encoder_tb;

  localparam int W  = 8;
  localparam int NF = 4;
  localparam int P  = 4;
  localparam int CW = W + P;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_flit = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [CW-1:0] out_flit;
  logic          out_last;
  logic          out_chk;
  logic          rtx_req = 1'b0;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pc_packet_encoder #(.FLIT_W(W), .MAX_FLITS(NF)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_flit(in_flit), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_flit(out_flit), .out_last(out_last),
    .out_chk(out_chk), .rtx_req(rtx_req)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Independent syndrome: XOR of codeword positions of set bits.
  function automatic int syn(input logic [CW-1:0] cw);
    int s = 0;
    int pos = 0;
    int d = 0;
    for (int p = 1; p <= CW; p++) begin
      if ((p & (p - 1)) == 0) begin
        if (cw[W + $clog2(p)]) s ^= p;
      end else begin
        if (cw[d]) s ^= p;
        d++;
      end
      pos = p;
    end
    return s + (pos - CW);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_flit(input logic [W-1:0] f, input bit lst, input bit exp_last);
    in_valid = 1'b1;
    in_flit  = f;
    in_last  = lst;
    while (!in_ready) step();
    step();
    in_valid = 1'b0;
    in_last  = 1'b0;
    check(out_valid == 1'b1, "R3", "out_valid after accept", out_valid, 1);
    check(out_flit[W-1:0] == f, "R2", "systematic data", out_flit[W-1:0], f);
    check(syn(out_flit) == 0, "R2", "data flit syndrome", syn(out_flit), 0);
    check(out_last == exp_last, "R4", "out_last", out_last, exp_last);
    check(out_chk == 1'b0, "R7", "data flit out_chk", out_chk, 0);
  endtask

  task automatic send_pkt(input logic [W-1:0] f [NF], input int n, input bit use_last,
                          output logic [W-1:0] par);
    par = '0;
    for (int i = 0; i < n; i++) begin
      par ^= f[i];
      send_flit(f[i], use_last && (i == n - 1), i == n - 1);
    end
  endtask

  task automatic request(input bit present, input logic [W-1:0] par, input string req);
    rtx_req = 1'b1;
    step();
    rtx_req = 1'b0;
    step();
    if (present) begin
      check(out_valid && out_chk, "R7", {req, " check flit present"}, {out_valid, out_chk}, 3);
      check(out_last == 1'b1, "R7", "check flit out_last", out_last, 1);
      check(out_flit[W-1:0] == par, "R5", "row parity", out_flit[W-1:0], par);
      check(syn(out_flit) == 0, "R6", "checks-on-checks syndrome", syn(out_flit), 0);
    end else begin
      check(out_valid == 1'b0, req, "no output on ignored request", out_valid, 0);
    end
    step();
    check(out_valid == 1'b0, "R8", "only one check flit", out_valid, 0);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    request(1'b0, '0, "R1");
  endtask

  task automatic t_full();
    logic [W-1:0] f [NF] = '{8'hA5, 8'h3C, 8'hFF, 8'h01};
    logic [W-1:0] par;
    send_pkt(f, 4, 1'b1, par);
    request(1'b1, par, "R5");
    request(1'b0, '0, "R8");
  endtask

  task automatic t_no_last();
    logic [W-1:0] f [NF] = '{8'h12, 8'h34, 8'h56, 8'h78};
    logic [W-1:0] par;
    send_pkt(f, 4, 1'b0, par);
    request(1'b1, par, "R4");
  endtask

  task automatic t_short();
    logic [W-1:0] f [NF] = '{8'h80, 8'h7F, 8'h00, 8'h00};
    logic [W-1:0] par;
    send_pkt(f, 2, 1'b1, par);
    request(1'b1, par, "R4");
    f[0] = 8'h5A;
    send_pkt(f, 1, 1'b1, par);
    request(1'b1, 8'h5A, "R5");
  endtask

  task automatic t_double_req();
    logic [W-1:0] f [NF] = '{8'h11, 8'h22, 8'h44, 8'h88};
    logic [W-1:0] par;
    send_pkt(f, 4, 1'b1, par);
    rtx_req = 1'b1;
    step();
    step();
    rtx_req = 1'b0;
    check(out_valid && out_chk, "R8", "first request served", {out_valid, out_chk}, 3);
    check(out_flit[W-1:0] == par, "R5", "row parity double req", out_flit[W-1:0], par);
    step();
    check(out_valid == 1'b0, "R8", "second request ignored", out_valid, 0);
    step();
    check(out_valid == 1'b0, "R8", "second request ignored later", out_valid, 0);
  endtask

  task automatic t_discard();
    logic [W-1:0] f [NF] = '{8'hC3, 8'h96, 8'h0F, 8'hF0};
    logic [W-1:0] g [NF] = '{8'h01, 8'h02, 8'h04, 8'h08};
    logic [W-1:0] par;
    send_pkt(f, 4, 1'b1, par);
    rtx_req = 1'b1;
    send_flit(g[0], 1'b0, 1'b0);
    rtx_req = 1'b0;
    step();
    check(out_valid == 1'b0, "R9", "request with first flit dropped", out_valid, 0);
    request(1'b0, '0, "R9");
    send_flit(g[1], 1'b0, 1'b0);
    send_flit(g[2], 1'b1, 1'b1);
    request(1'b1, 8'h07, "R9");
  endtask

  task automatic t_backpressure();
    logic [W-1:0] par;
    out_ready = 1'b0;
    in_valid = 1'b1; in_flit = 8'h9C; in_last = 1'b0;
    step();
    check(in_ready == 1'b0, "R10", "in_ready under stall", in_ready, 0);
    in_flit = 8'h63;
    step();
    check(out_valid && out_flit[W-1:0] == 8'h9C, "R10", "output held", out_flit[W-1:0], 8'h9C);
    check(in_ready == 1'b0, "R10", "in_ready still low", in_ready, 0);
    out_ready = 1'b1;
    step();
    in_valid = 1'b0;
    check(out_flit[W-1:0] == 8'h63, "R3", "next flit in order", out_flit[W-1:0], 8'h63);
    send_flit(8'h10, 1'b1, 1'b1);
    par = 8'h9C ^ 8'h63 ^ 8'h10;
    request(1'b1, par, "R10");
  endtask

  task automatic t_pend_block();
    logic [W-1:0] par;
    send_flit(8'hE7, 1'b1, 1'b1);
    rtx_req = 1'b1;
    step();
    rtx_req = 1'b0;
    in_valid = 1'b1; in_flit = 8'h24; in_last = 1'b1;
    check(in_ready == 1'b0, "R11", "in_ready while pending", in_ready, 0);
    step();
    check(out_chk && out_flit[W-1:0] == 8'hE7, "R11", "check flit before new data",
          out_flit[W-1:0], 8'hE7);
    step();
    in_valid = 1'b0; in_last = 1'b0;
    check(out_valid && !out_chk && out_flit[W-1:0] == 8'h24, "R11", "held flit sent after",
          out_flit[W-1:0], 8'h24);
    par = 8'h24;
    request(1'b1, par, "R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full();
    t_no_last();
    t_short();
    t_double_req();
    t_discard();
    t_backpressure();
    t_pend_block();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      vecs++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule